// File: doc/BRIEF.md
# Program/Data Space Memory Enable Mapper

This block sits between an 8-bit microcontroller with separate program and data address spaces and three on-chip memories: a primary flash, a secondary flash and an SRAM. For each memory it combines the chip select, which an external address decoder produces, with the two active-low access strobes of the microcontroller. One strobe fetches program code and the other reads data. The result drives that memory's active-low output enable.

An 8-bit mode register holds one permission bit for each memory and each strobe. It therefore decides whether a memory appears in program space, in data space, or in both. The register takes a parameterised value in reset. The microcontroller can rewrite it at run time through a select/write/data bus, so it can, for example, exchange the two flash memories between the spaces without stopping. The SRAM always answers data reads. Only its program-fetch path is switchable. The top bit of the register is passed out as a port-mode flag for logic elsewhere.

Top module: `mem_space_gate`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising clk edge), the mode register holds parameter RESET_MODE with bits 6 and 5 forced to 0. The default RESET_MODE is 8'h0C: primary flash in program space only, secondary flash and SRAM in data space only.
- R2: At a rising clk edge with rst_n high, reg_sel high and reg_wr high, the register takes reg_wdata with bits 6 and 5 cleared. Those two bits always read as 0.
- R3: When reg_sel or reg_wr is low at an edge, the register keeps its value.
- R4: reg_rdata equals the register contents while reg_sel is high, and 8'h00 while reg_sel is low.
- R5: Primary flash: oe_pflash_n is low when cs_pflash is high and either data_rd_n is low with register bit 4 set, or prog_rd_n is low with register bit 2 set. Otherwise it is high.
- R6: Secondary flash: oe_sflash_n is low when cs_sflash is high and either data_rd_n is low with bit 3 set, or prog_rd_n is low with bit 1 set. Otherwise it is high.
- R7: SRAM: oe_sram_n is low when cs_sram is high and either data_rd_n is low (whatever the register holds), or prog_rd_n is low with bit 0 set. Otherwise it is high.
- R8: Every output enable is high while its chip select is low, and high while both strobes are high.
- R9: port_mode equals register bit 7.
- R10: A register write changes the output enables within the same clock cycle that follows the write edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Mode register select |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Register read data, 0 when not selected |
| prog_rd_n | input | 1 | Program-fetch strobe, active low |
| data_rd_n | input | 1 | Data-read strobe, active low |
| cs_pflash | input | 1 | Primary flash chip select |
| cs_sflash | input | 1 | Secondary flash chip select |
| cs_sram | input | 1 | SRAM chip select |
| oe_pflash_n | output | 1 | Primary flash output enable, active low |
| oe_sflash_n | output | 1 | Secondary flash output enable, active low |
| oe_sram_n | output | 1 | SRAM output enable, active low |
| port_mode | output | 1 | Register bit 7 |

## Verification
The assertions assume that the strobes, chip selects and bus inputs are stable and free of X at each rising edge once reset has been released. The bench therefore changes every input just after a falling edge and holds it through the next rising edge. The assertions do not assume that the two strobes are mutually exclusive. For this reason the stimulus sweeps all four strobe combinations, including both strobes low together, for every register value and every chip-select pattern. Random register writes, some with the select or the write strobe dropped, are interleaved with these sweeps.

// File: rtl/mem_space_pkg.sv
// Shared constants for the memory space mapper: memory indices and
// the bit positions of the mode register that the gating decodes.
package mem_space_pkg;
    localparam int REG_W   = 8;
    localparam int NUM_MEM = 3;

    typedef enum logic [1:0] {
        MEM_PFLASH = 2'd0,
        MEM_SFLASH = 2'd1,
        MEM_SRAM   = 2'd2
    } mem_id_e;

    // Bit positions in the mode register (fixed by behaviour).
    localparam int B_PORT_MODE = 7;
    localparam int B_DRD_PF    = 4;
    localparam int B_DRD_SF    = 3;
    localparam int B_PRD_PF    = 2;
    localparam int B_PRD_SF    = 1;
    localparam int B_PRD_SR    = 0;

    // Bits that exist in the register; the others read as zero.
    localparam logic [REG_W-1:0] LIVE_MASK = 8'h9F;
endpackage

// File: rtl/mode_reg.sv
// Mode register: loads RESET_VAL on synchronous reset and takes bus
// writes when selected. Assumes the bus inputs are stable at the edge.
module mode_reg
    import mem_space_pkg::*;
#(
    parameter logic [REG_W-1:0] RESET_VAL = 8'h0C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic [REG_W-1:0] mode
);
    logic wr_hit;
    assign wr_hit = sel & wr;

    // Register update: reset load or selected write, unused bits masked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= RESET_VAL & LIVE_MASK;
        else if (wr_hit)
            mode <= wdata & LIVE_MASK;
    end

    // Read path: contents only while selected.
    always_comb begin
        rdata = sel ? mode : '0;
    end

    // R2: a selected write lands on the next edge
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr) |=> (mode == ($past(wdata) & LIVE_MASK)));

    // R3: no write, no change
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && wr) |=> $stable(mode));

    // R4: read data is silent while deselected
    p_rd_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (rdata == '0));
endmodule

// File: rtl/oe_gate.sv
// Output-enable gate for one memory: enable is asserted (low) when the
// chip select is high and a permitted strobe is low. Clock and reset
// feed only the assertions.
module oe_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic prog_rd_n,
    input  logic data_rd_n,
    input  logic prog_ok,
    input  logic data_ok,
    output logic oe_n
);
    logic hit;

    // Gate: any permitted active strobe with chip select opens the memory.
    always_comb begin
        hit  = (!prog_rd_n && prog_ok) || (!data_rd_n && data_ok);
        oe_n = !(cs && hit);
    end

    // R8: deselected memory never drives
    p_cs_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> oe_n);

    // R8: no strobe, no enable
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_rd_n && data_rd_n) |-> oe_n);

    // R5/R6/R7: a blocked strobe alone cannot open the memory
    p_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_ok && data_rd_n) |-> oe_n);
endmodule

// File: rtl/mem_space_gate.sv
// Program/data space mapper top: mode register plus one gate per memory.
// Assumes chip selects come from an external decoder.
module mem_space_gate
    import mem_space_pkg::*;
#(
    parameter logic [7:0] RESET_MODE = 8'h0C
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_sel,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       prog_rd_n,
    input  logic       data_rd_n,
    input  logic       cs_pflash,
    input  logic       cs_sflash,
    input  logic       cs_sram,
    output logic       oe_pflash_n,
    output logic       oe_sflash_n,
    output logic       oe_sram_n,
    output logic       port_mode
);
    logic [REG_W-1:0]   mode;
    logic [NUM_MEM-1:0] cs_v, prog_ok, data_ok, oe_v;

    mode_reg #(.RESET_VAL(RESET_MODE)) u_reg (
        .clk(clk), .rst_n(rst_n), .sel(reg_sel), .wr(reg_wr),
        .wdata(reg_wdata), .rdata(reg_rdata), .mode(mode)
    );

    // Permission decode: map register bits onto each memory's strobes.
    always_comb begin
        cs_v                = '0;
        cs_v[MEM_PFLASH]    = cs_pflash;
        cs_v[MEM_SFLASH]    = cs_sflash;
        cs_v[MEM_SRAM]      = cs_sram;
        prog_ok             = '0;
        prog_ok[MEM_PFLASH] = mode[B_PRD_PF];
        prog_ok[MEM_SFLASH] = mode[B_PRD_SF];
        prog_ok[MEM_SRAM]   = mode[B_PRD_SR];
        data_ok             = '0;
        data_ok[MEM_PFLASH] = mode[B_DRD_PF];
        data_ok[MEM_SFLASH] = mode[B_DRD_SF];
        data_ok[MEM_SRAM]   = 1'b1;
    end

    for (genvar m = 0; m < NUM_MEM; m++) begin : g_mem
        oe_gate u_gate (
            .clk(clk), .rst_n(rst_n), .cs(cs_v[m]),
            .prog_rd_n(prog_rd_n), .data_rd_n(data_rd_n),
            .prog_ok(prog_ok[m]), .data_ok(data_ok[m]), .oe_n(oe_v[m])
        );
    end

    // Output mapping.
    always_comb begin
        oe_pflash_n = oe_v[MEM_PFLASH];
        oe_sflash_n = oe_v[MEM_SFLASH];
        oe_sram_n   = oe_v[MEM_SRAM];
        port_mode   = mode[B_PORT_MODE];
    end

    // R7: a data read of a selected SRAM always enables it
    p_sram_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_sram && !data_rd_n) |-> !oe_sram_n);

    // R2: unused register bits read back as zero
    p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> (reg_rdata[6:5] == 2'b00));
endmodule

// File: tb/sim_mem_space_gate.sv
module sim_mem_space_gate;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       prog_rd_n = 1'b1, data_rd_n = 1'b1;
    logic       cs_pflash = 1'b0, cs_sflash = 1'b0, cs_sram = 1'b0;
    logic       oe_pflash_n, oe_sflash_n, oe_sram_n, port_mode;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_space_gate u0 (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .prog_rd_n(prog_rd_n), .data_rd_n(data_rd_n),
        .cs_pflash(cs_pflash), .cs_sflash(cs_sflash), .cs_sram(cs_sram),
        .oe_pflash_n(oe_pflash_n), .oe_sflash_n(oe_sflash_n),
        .oe_sram_n(oe_sram_n), .port_mode(port_mode)
    );

    // Expected enables {sram, sflash, pflash}, active low, from R5..R7.
    function automatic logic [2:0] exp_oe(input logic [7:0] m, input logic pn,
                                          input logic dn, input logic [2:0] cs);
        logic pf, sf, sr;
        pf = cs[0] && ((!dn && m[4]) || (!pn && m[2]));
        sf = cs[1] && ((!dn && m[3]) || (!pn && m[1]));
        sr = cs[2] && (!dn || (!pn && m[0]));
        return ~{sr, sf, pf};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic sel, input logic wr, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wr = wr; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic read_reg(input string tag, input logic [7:0] exp);
        @(negedge clk);
        reg_sel = 1'b1; #2;
        chk(tag, reg_rdata, exp);
        reg_sel = 1'b0; #1;
        chk("R4 deselected read", reg_rdata, 8'h00);
    endtask

    // Full strobe/chip-select sweep for the current mode m.
    task automatic sweep(input logic [7:0] m);
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            {data_rd_n, prog_rd_n, cs_sram, cs_sflash, cs_pflash} = k[4:0];
            #2;
            chk("R5 R6 R7 R8 enables", {5'd0, oe_sram_n, oe_sflash_n, oe_pflash_n},
                {5'd0, exp_oe(m, prog_rd_n, data_rd_n, {cs_sram, cs_sflash, cs_pflash})});
        end
        prog_rd_n = 1'b1; data_rd_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] model;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset value
        model = 8'h0C;
        read_reg("R1 reset value", model);
        chk("R9 port_mode after reset", {7'd0, port_mode}, 8'h00);
        sweep(model);

        // R2/R10: every register value, enables checked right after the write
        for (int v = 0; v < 256; v++) begin
            bus_write(1'b1, 1'b1, v[7:0]);
            model = v[7:0] & 8'h9F;
            // R10: first cycle after the write edge
            prog_rd_n = 1'b0; cs_pflash = 1'b1; cs_sflash = 1'b1; cs_sram = 1'b1; #1;
            chk("R10 immediate effect", {5'd0, oe_sram_n, oe_sflash_n, oe_pflash_n},
                {5'd0, exp_oe(model, 1'b0, 1'b1, 3'b111)});
            prog_rd_n = 1'b1;
            read_reg("R2 write readback", model);
            chk("R9 port_mode", {7'd0, port_mode}, {7'd0, model[7]});
            sweep(model);
        end

        // R3: writes without select or without strobe are ignored
        bus_write(1'b1, 1'b1, 8'h0C); model = 8'h0C;
        bus_write(1'b0, 1'b1, 8'hFF);
        read_reg("R3 write without select", model);
        bus_write(1'b1, 1'b0, 8'h93);
        read_reg("R3 select without write", model);
        sweep(model);

        // Random mixture of writes and probes
        for (int i = 0; i < 1500; i++) begin
            logic [7:0] d; logic s, w; logic [4:0] pat;
            d = 8'($urandom); s = 1'($urandom); w = 1'($urandom);
            bus_write(s, w, d);
            if (s && w) model = d & 8'h9F;
            pat = 5'($urandom);
            @(negedge clk);
            {data_rd_n, prog_rd_n, cs_sram, cs_sflash, cs_pflash} = pat;
            #2;
            chk("R5 R6 R7 random", {5'd0, oe_sram_n, oe_sflash_n, oe_pflash_n},
                {5'd0, exp_oe(model, prog_rd_n, data_rd_n, {cs_sram, cs_sflash, cs_pflash})});
            if (i % 50 == 0) read_reg("R3 R4 random readback", model);
        end

        // R1: reset again restores the default
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        read_reg("R1 reset after run", 8'h0C);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule